// File: doc/BRIEF.md
# Dual-Domain Register Scoreboard

This block keeps, for every warp, a record of which destination registers still have a write in flight. The issue stage consults it before launching an instruction. An instruction is held back while any of its source registers is still waiting for a result.

Each tracked register sits in one of two release domains, and the operation class chosen at issue decides which one.

- **Fixed-latency domain.** Arithmetic, special-function and shared-memory results clear themselves. At issue, a per-register down-counter is loaded with the known latency of that class. The register becomes usable again when the counter runs out.
- **Variable-latency domain.** Global-memory loads hold their mark for as long as it takes. The mark is released only by an explicit writeback from the memory side.

A combinational query port checks up to three source registers of one warp against both domains at once. A sticky flag records any writeback that finds nothing to release.

Top module: `sb_scoreboard`

## Requirements
- R1: After synchronous reset, every register of every warp reports ready and `wb_err` is 0.
- R2: An accepted issue of class code 0 (integer/FP32 arithmetic) makes the destination not ready for exactly 4 clock cycles following the issue edge. It is ready from the 5th cycle on.
- R3: An accepted issue of class code 1 (special function) makes the destination not ready for exactly 16 cycles following the issue edge.
- R4: An accepted issue of class code 2 (shared-memory load) makes the destination not ready for exactly 23 cycles following the issue edge.
- R5: An accepted issue of class code 3 (global-memory load) keeps the destination not ready with no time limit. It becomes ready in the cycle after a writeback to that warp and register is sampled.
- R6: `q_ready` is 0 exactly when some source slot i with `q_use[i]`=1 names a register of warp `q_warp` that is pending in either domain. Slot 0, 1 and 2 are `q_src0`, `q_src1` and `q_src2`. Disabled slots and other warps have no effect.
- R7: An issue to a register that is already pending in either domain is discarded. The existing entry keeps its domain and its remaining time.
- R8: A writeback to a register with no variable-latency mark changes no register's status. It sets `wb_err` in the following cycle, and `wb_err` stays 1 until reset.
- R9: An issue and a writeback in the same cycle to different registers both take effect.
- R10: A register whose countdown expired is usable in that same cycle. An issue to it in the first cycle it reads ready is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_warp | input | log2(NUM_WARPS) | Issuing warp |
| iss_reg | input | log2(NUM_REGS) | Destination register |
| iss_cls | input | 2 | Operation class: 0 arithmetic, 1 special function, 2 shared load, 3 global load |
| wb_valid | input | 1 | Variable-latency writeback strobe |
| wb_warp | input | log2(NUM_WARPS) | Writeback warp |
| wb_reg | input | log2(NUM_REGS) | Writeback register |
| q_warp | input | log2(NUM_WARPS) | Warp being queried |
| q_src0 | input | log2(NUM_REGS) | Source register, slot 0 |
| q_src1 | input | log2(NUM_REGS) | Source register, slot 1 |
| q_src2 | input | log2(NUM_REGS) | Source register, slot 2 |
| q_use | input | 3 | Per-slot enable |
| q_ready | output | 1 | All enabled sources free |
| wb_err | output | 1 | Sticky stray-writeback flag |

## Verification
Two pairs of functions can fall in the same cycle.

- **Writeback and issue together.** The bench parks a global load on one register. In a single cycle it then releases that register by writeback and issues an arithmetic write to a second register of the same warp. It judges the result by requiring the first register ready at once and the second busy for its full 4 cycles.
- **Countdown expiry and re-issue.** The bench polls a register until it first turns ready. In that same cycle it issues a new write to it, and requires the new countdown to run its full length.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OP_ALU  = 2'd0,
    OP_SFU  = 2'd1,
    OP_SMEM = 2'd2,
    OP_GMEM = 2'd3
  } op_class_e;
endpackage

// File: rtl/sb_short_timers.sv
module sb_short_timers #(
  parameter int N     = 64,
  parameter int CNT_W = 5,
  localparam int IW   = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [IW-1:0]    load_idx,
  input  logic [CNT_W-1:0] load_val,
  output logic [N-1:0]     busy
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)
        cnt <= '0;
      else if (load_en && load_idx == IW'(i))
        cnt <= load_val;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
    assign busy[i] = |cnt;
  end
endmodule

// File: rtl/sb_long_flags.sv
module sb_long_flags #(
  parameter int N   = 64,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  busy
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        busy[i] <= 1'b0;
      else if (clr_en && clr_idx == IW'(i))
        busy[i] <= 1'b0;
      else if (set_en && set_idx == IW'(i))
        busy[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sb_query.sv
module sb_query #(
  parameter int N    = 64,
  parameter int NSRC = 3,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]             pend,
  input  logic [NSRC-1:0][IW-1:0]  idx,
  input  logic [NSRC-1:0]          src_en,
  output logic                     ready
);
  always_comb begin
    ready = 1'b1;
    for (int s = 0; s < NSRC; s++)
      if (src_en[s] && pend[idx[s]])
        ready = 1'b0;
  end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 16,
  parameter int LAT_ALU   = 4,
  parameter int LAT_SFU   = 16,
  parameter int LAT_SMEM  = 23,
  localparam int WW       = $clog2(NUM_WARPS),
  localparam int RW       = $clog2(NUM_REGS),
  localparam int IW       = WW + RW,
  localparam int N        = NUM_WARPS * NUM_REGS,
  localparam int LAT_MAX  = (LAT_ALU > LAT_SFU) ? ((LAT_ALU > LAT_SMEM) ? LAT_ALU : LAT_SMEM)
                                               : ((LAT_SFU > LAT_SMEM) ? LAT_SFU : LAT_SMEM),
  localparam int CNT_W    = $clog2(LAT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [WW-1:0] iss_warp,
  input  logic [RW-1:0] iss_reg,
  input  logic [1:0]    iss_cls,
  input  logic          wb_valid,
  input  logic [WW-1:0] wb_warp,
  input  logic [RW-1:0] wb_reg,
  input  logic [WW-1:0] q_warp,
  input  logic [RW-1:0] q_src0,
  input  logic [RW-1:0] q_src1,
  input  logic [RW-1:0] q_src2,
  input  logic [2:0]    q_use,
  output logic          q_ready,
  output logic          wb_err
);
  logic [N-1:0]         sh_busy;
  logic [N-1:0]         lg_busy;
  logic [N-1:0]         pend;
  logic [IW-1:0]        iss_idx;
  logic [IW-1:0]        wb_idx;
  logic                 iss_ok;
  logic                 wb_hit;
  logic [CNT_W-1:0]     lat_sel;
  logic [2:0][IW-1:0]   q_idx;
  op_class_e            cls;

  assign iss_idx = {iss_warp, iss_reg};
  assign wb_idx  = {wb_warp, wb_reg};
  assign pend    = sh_busy | lg_busy;
  assign cls     = op_class_e'(iss_cls);
  // A destination with any live entry blocks the new write.
  assign iss_ok  = iss_valid && !pend[iss_idx];
  assign wb_hit  = wb_valid && lg_busy[wb_idx];

  always_comb begin
    case (cls)
      OP_SFU:  lat_sel = CNT_W'(LAT_SFU);
      OP_SMEM: lat_sel = CNT_W'(LAT_SMEM);
      default: lat_sel = CNT_W'(LAT_ALU);
    endcase
  end

  sb_short_timers #(.N(N), .CNT_W(CNT_W)) u_timers (
    .clk      (clk),
    .rst      (rst),
    .load_en  (iss_ok && cls != OP_GMEM),
    .load_idx (iss_idx),
    .load_val (lat_sel),
    .busy     (sh_busy)
  );

  sb_long_flags #(.N(N)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_en  (iss_ok && cls == OP_GMEM),
    .set_idx (iss_idx),
    .clr_en  (wb_hit),
    .clr_idx (wb_idx),
    .busy    (lg_busy)
  );

  assign q_idx = {{q_warp, q_src2}, {q_warp, q_src1}, {q_warp, q_src0}};

  sb_query #(.N(N), .NSRC(3)) u_query (
    .pend   (pend),
    .idx    (q_idx),
    .src_en (q_use),
    .ready  (q_ready)
  );

  always_ff @(posedge clk) begin
    if (rst)
      wb_err <= 1'b0;
    else if (wb_valid && !lg_busy[wb_idx])
      wb_err <= 1'b1;
  end
endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 16,
  localparam int WW       = $clog2(NUM_WARPS),
  localparam int RW       = $clog2(NUM_REGS),
  localparam int N        = NUM_WARPS * NUM_REGS
) (
  input logic          clk,
  input logic          rst,
  input logic          iss_valid,
  input logic [WW-1:0] iss_warp,
  input logic [RW-1:0] iss_reg,
  input logic [1:0]    iss_cls,
  input logic          wb_valid,
  input logic [WW-1:0] wb_warp,
  input logic [RW-1:0] wb_reg,
  input logic [WW-1:0] q_warp,
  input logic [RW-1:0] q_src0,
  input logic [RW-1:0] q_src1,
  input logic [RW-1:0] q_src2,
  input logic [2:0]    q_use,
  input logic          q_ready,
  input logic          wb_err,
  input logic [N-1:0]  sh_busy,
  input logic [N-1:0]  lg_busy
);
  logic [N-1:0]       pnd;
  logic [WW+RW-1:0]   ii, wi, a0, a1, a2;
  assign pnd = sh_busy | lg_busy;
  assign ii  = {iss_warp, iss_reg};
  assign wi  = {wb_warp, wb_reg};
  assign a0  = {q_warp, q_src0};
  assign a1  = {q_warp, q_src1};
  assign a2  = {q_warp, q_src2};

  // R1
  reset_err_low_chk: assert property (@(posedge clk) rst |=> !wb_err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) wb_err |=> wb_err);

  // R8
  err_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !lg_busy[wi]) |=> wb_err);

  // R2
  short_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !pnd[ii] && iss_cls != 2'd3) |=> sh_busy[$past(ii)]);

  // R5
  long_release_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && lg_busy[wi]) |=> !lg_busy[$past(wi)]);

  // R7
  no_domain_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && lg_busy[ii] && iss_cls != 2'd3) |=> !sh_busy[$past(ii)]);

  // R6
  query_block_chk: assert property (@(posedge clk) disable iff (rst)
    ((q_use[0] && pnd[a0]) || (q_use[1] && pnd[a1]) || (q_use[2] && pnd[a2])) |-> !q_ready);

  // R6
  query_free_chk: assert property (@(posedge clk) disable iff (rst)
    !q_ready |-> ((q_use[0] && pnd[a0]) || (q_use[1] && pnd[a1]) || (q_use[2] && pnd[a2])));

  for (genvar k = 0; k < N; k++) begin : g_hold
    // R5
    long_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (lg_busy[k] && !(wb_valid && wi == (WW+RW)'(k))) |=> lg_busy[k]);
  end
endmodule

bind sb_scoreboard sb_scoreboard_chk #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_reg(iss_reg),
  .iss_cls(iss_cls), .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
  .q_warp(q_warp), .q_src0(q_src0), .q_src1(q_src1), .q_src2(q_src2), .q_use(q_use),
  .q_ready(q_ready), .wb_err(wb_err), .sh_busy(sh_busy), .lg_busy(lg_busy)
);

// File: tb/tb_sb_scoreboard.sv
module tb_sb_scoreboard;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int NR = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       iss_valid = 1'b0;
  logic [1:0] iss_warp = '0;
  logic [3:0] iss_reg = '0;
  logic [1:0] iss_cls = '0;
  logic       wb_valid = 1'b0;
  logic [1:0] wb_warp = '0;
  logic [3:0] wb_reg = '0;
  logic [1:0] q_warp = '0;
  logic [3:0] q_src0 = '0, q_src1 = '0, q_src2 = '0;
  logic [2:0] q_use = '0;
  logic       q_ready, wb_err;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sb_scoreboard #(.NUM_WARPS(NW), .NUM_REGS(NR)) dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_reg(iss_reg),
    .iss_cls(iss_cls), .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .q_warp(q_warp), .q_src0(q_src0), .q_src1(q_src1), .q_src2(q_src2), .q_use(q_use),
    .q_ready(q_ready), .wb_err(wb_err)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    vectors++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  task automatic chk(int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic issue(int w, int r, int c);
    iss_valid = 1'b1; iss_warp = 2'(w); iss_reg = 4'(r); iss_cls = 2'(c);
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic wback(int w, int r);
    wb_valid = 1'b1; wb_warp = 2'(w); wb_reg = 4'(r);
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic setq(int w, int r, int slot);
    q_warp = 2'(w);
    q_src0 = 4'(r + 1); q_src1 = 4'(r + 2); q_src2 = 4'(r + 3);
    case (slot)
      0: q_src0 = 4'(r);
      1: q_src1 = 4'(r);
      default: q_src2 = 4'(r);
    endcase
    q_use = 3'(1 << slot);
  endtask

  task automatic peek(output int v);
    #1 v = int'(q_ready);
  endtask

  task automatic count_busy(int limit, output int n);
    int v;
    n = 0;
    forever begin
      peek(v);
      if (v == 1 || n > limit) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int v, n;
    int lat[3] = '{4, 16, 23};
    do_reset();

    // R1: everything ready after reset
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++) begin
        setq(w, r, 0); peek(v); chk(v, 1, "R1 ready after reset");
      end
    chk(int'(wb_err), 0, "R1 error flag after reset");

    // R2 R3 R4 R6: full sweep of fixed-latency classes, rotating query slot
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < 3; c++) begin
          setq(w, r, (r + c) % 3);
          @(negedge clk);
          issue(w, r, c);
          count_busy(40, n);
          chk(n, lat[c], c == 0 ? "R2 alu latency" : (c == 1 ? "R3 sfu latency" : "R4 smem latency"));
        end

    // R5 R6: global load held indefinitely
    issue(1, 5, 3);
    setq(2, 5, 0); peek(v); chk(v, 1, "R6 other warp unaffected");
    q_warp = 2'd1; q_src0 = 4'd3; q_src1 = 4'd5; q_src2 = 4'd7; q_use = 3'b111;
    peek(v); chk(v, 0, "R6 pending in slot 1 blocks");
    q_use = 3'b101; peek(v); chk(v, 1, "R6 disabled slot ignored");
    setq(1, 5, 0);
    repeat (300) @(negedge clk);
    peek(v); chk(v, 0, "R5 long entry still pending");
    wback(1, 5);
    peek(v); chk(v, 1, "R5 ready after writeback");
    chk(int'(wb_err), 0, "R5 no error on matched writeback");

    // R7: reissue to pending registers discarded
    setq(0, 2, 0);
    issue(0, 2, 0);
    issue(0, 2, 1);
    count_busy(40, n); chk(n, 3, "R7 short entry keeps original time");
    setq(0, 3, 1);
    issue(0, 3, 3);
    issue(0, 3, 0);
    repeat (10) @(negedge clk);
    peek(v); chk(v, 0, "R7 long entry not replaced");
    wback(0, 3);
    peek(v); chk(v, 1, "R7 release by writeback");

    // R10: reissue on first ready cycle
    setq(2, 9, 2);
    issue(2, 9, 0);
    count_busy(40, n); chk(n, 4, "R10 first countdown");
    issue(2, 9, 1);
    count_busy(40, n); chk(n, 16, "R10 reissue accepted at expiry");

    // R9: writeback and issue in one cycle
    issue(3, 1, 3);
    wb_valid = 1'b1; wb_warp = 2'd3; wb_reg = 4'd1;
    iss_valid = 1'b1; iss_warp = 2'd3; iss_reg = 4'd4; iss_cls = 2'd0;
    @(negedge clk);
    wb_valid = 1'b0; iss_valid = 1'b0;
    setq(3, 1, 0); peek(v); chk(v, 1, "R9 writeback applied");
    setq(3, 4, 1); count_busy(40, n); chk(n, 4, "R9 issue applied");
    chk(int'(wb_err), 0, "R9 no error");

    // R8: stray writebacks
    do_reset();
    wback(0, 0);
    chk(int'(wb_err), 1, "R8 stray writeback flags");
    repeat (5) @(negedge clk);
    chk(int'(wb_err), 1, "R8 flag sticky");
    do_reset();
    chk(int'(wb_err), 0, "R1 reset clears flag");
    setq(1, 8, 0);
    issue(1, 8, 0);
    wback(1, 8);
    count_busy(40, n); chk(n, 3, "R8 short entry untouched by writeback");
    chk(int'(wb_err), 1, "R8 writeback to short entry flags");

    summary();
  end
endmodule